// File: doc/BRIEF.md
# Sequential-Trigger State Capture Engine

This block is the acquisition core of a logic state analyser. A wide probe bus is sampled once for every rising edge of an external qualifying clock. That clock is brought into the system clock domain through a synchroniser, and its rising edge is detected there. A trigger sequencer waits for an ordered series of masked patterns. The last pattern in the series must also be seen a set number of times. A separate restart pattern sends the sequencer back to its first step. Samples that pass a storage qualifier are written into a small circular trace memory. Each stored sample carries a tag: either the system clock cycles or the sampled states counted since the previous stored sample.

Software programs the engine through a write-only register port and then starts a capture by writing the arm register. The trigger position decides how many samples are stored after the trigger:

- start mode: all samples after the trigger, until the memory is full
- centre mode: half the memory after the trigger
- end mode: none after the trigger

When capture ends, `done` rises. Software reads the window back by index, with index 0 the oldest sample, and uses `trig_idx` to locate the trigger sample. Two health indicators are also provided. One warns that the external clock has stopped. The other is a per-group flag that shows recent toggling on each byte group of the probe bus.

Register map on `cfg_addr`:

| Address | Contents |
|---|---|
| 0..7 | Value of sequence step k |
| 8..15 | Care mask of step k (bit 1 = compare this bit) |
| 16 | Control: bits [2:0] index of the last step; bits [4:3] position (0 start, 1 centre, 2 or 3 end); bit 5 store every state; bit 6 tag counts sampled states instead of cycles |
| 17 | Occurrence count (0 is treated as 1) |
| 18 | Restart value |
| 19 | Restart mask (an all-zero mask disables restart) |
| 20 | Qualifier value |
| 21 | Qualifier mask |
| 22 | Arm (any write data) |

States of the capture controller:

- IDLE: entered after reset. Samples are ignored.
- PRE: entered on arm. The engine hunts for the trigger. In centre and end modes it stores qualified samples circularly.
- POST: entered when the trigger is found and samples still remain to be stored after it. Qualified samples are stored until that number is reached.
- DONE: capture is frozen. Only a new arm leaves this state.

Transitions:

- any state to PRE on arm
- PRE to DONE on a trigger in end mode
- PRE to POST on a trigger in the other modes
- POST to DONE when the last sample after the trigger is stored

Top module: `seqtrig_capture`

## Requirements
- R1: The probe bus is captured once per rising edge of `ext_clk`, and the stored word equals the bus value present at that edge.
- R2: A sequence step matches when `(probe ^ value) & mask == 0`. Steps 0 to the last step index must match in order, and samples that match no pending step between them are allowed.
- R3: The trigger fires on the Nth match of the last step, where N is the occurrence count (N=0 behaves as 1).
- R4: A sample that matches the enabled restart pattern returns the sequencer to step 0 and clears the occurrence count, so a sequence broken by it does not trigger.
- R5: Start mode stores the trigger sample at index 0 followed by 63 more samples, giving `trace_len`=64. Once `done` is high, further samples leave `trace_len` unchanged until the next arm.
- R6: Centre mode stores exactly 32 samples after the trigger. The memory wraps before the trigger, so `trig_idx` gives the trigger's position in the read window (31 when the window is full).
- R7: End mode sets `done` on the trigger sample itself, which is the newest entry (`trig_idx` = `trace_len`-1).
- R8: With store-all clear, only samples that satisfy `(probe ^ qval) & qmask == 0` are stored. The trigger sample is always stored.
- R9: In cycle tag mode, a tag equals the system clock cycles between this store and the previous one, saturating at all ones.
- R10: In state tag mode, a tag equals the number of sampled states since the previous stored sample, this one included.
- R11: `slow_warn` is high once `ext_clk` has shown no rising edge for SLOW_LIM cycles, and it drops after the next edge.
- R12: `act_flags[g]` is high for ACT_WIN cycles after a sample in which byte group g differed from the previous sample, and low otherwise.
- R13: After reset, `done`, `trace_len`, `slow_warn` and `act_flags` are 0. An arm clears `done` and `trace_len` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and time-reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External qualifying clock (asynchronous) |
| probe | input | DW | Probe bus being sampled |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| rd_idx | input | log2(DEPTH) | Read index, 0 = oldest stored sample |
| rd_sample | output | DW | Stored sample at `rd_idx` |
| rd_tag | output | TAGW | Tag of the sample at `rd_idx` |
| trace_len | output | log2(DEPTH)+1 | Number of valid samples in the window |
| trig_idx | output | log2(DEPTH) | Index of the trigger sample in the window |
| done | output | 1 | Capture complete |
| slow_warn | output | 1 | External clock has stalled |
| act_flags | output | GROUPS | Recent-toggle flag per probe group |

## Verification
The properties assume that the probe bus stays stable for at least three system clocks after each rising edge of `ext_clk`. They also assume that a high or low phase of `ext_clk` lasts at least two system clocks, so that every edge is seen exactly once after synchronisation. The stimulus meets both conditions: each probe value is changed only at the same moment as the rise, then held for four cycles high and three cycles low. Arm writes are separated from sample edges by whole clock periods. The properties also assume that software never writes an index of the last step beyond STEPS-1, and the bench only writes 1 or 2.

// File: rtl/stc_pkg.sv
package stc_pkg;

    localparam int CFG_AW     = 5;
    localparam int A_STEP_VAL = 0;
    localparam int A_STEP_MSK = 8;
    localparam int A_CTRL     = 16;
    localparam int A_OCC      = 17;
    localparam int A_RST_VAL  = 18;
    localparam int A_RST_MSK  = 19;
    localparam int A_QUAL_VAL = 20;
    localparam int A_QUAL_MSK = 21;
    localparam int A_ARM      = 22;

    typedef enum logic [1:0] {
        POS_START  = 2'd0,
        POS_CENTRE = 2'd1,
        POS_END    = 2'd2,
        POS_END2   = 2'd3
    } pos_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

endpackage

// File: rtl/stc_sampler.sv
module stc_sampler #(
    parameter int DW       = 32,
    parameter int GROUPS   = 4,
    parameter int SLOW_LIM = 100000,
    parameter int ACT_WIN  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic [DW-1:0]     probe,
    output logic              smp_v,
    output logic [DW-1:0]     smp_d,
    output logic              slow_warn,
    output logic [GROUPS-1:0] act_flags
);
    localparam int GW = DW / GROUPS;
    localparam int SW = $clog2(SLOW_LIM + 1);
    localparam int AW = $clog2(ACT_WIN + 1);

    logic [2:0]    sync_q;
    logic          rise;
    logic [DW-1:0] prev_d;
    logic [SW-1:0] idle_q;

    assign rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            smp_v  <= 1'b0;
            smp_d  <= '0;
            prev_d <= '0;
            idle_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ext_clk};
            smp_v  <= rise;
            if (rise) smp_d <= probe;
            if (smp_v) prev_d <= smp_d;
            if (rise) idle_q <= '0;
            else if (idle_q != SW'(SLOW_LIM)) idle_q <= idle_q + 1'b1;
        end
    end

    assign slow_warn = (idle_q == SW'(SLOW_LIM));

    for (genvar g = 0; g < GROUPS; g++) begin : g_act
        logic [AW-1:0] win_q;
        logic          tog;
        assign tog = smp_v && (|(smp_d[g*GW +: GW] ^ prev_d[g*GW +: GW]));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              win_q <= '0;
            else if (tog)            win_q <= AW'(ACT_WIN);
            else if (win_q != '0)    win_q <= win_q - 1'b1;
        end
        assign act_flags[g] = (win_q != '0);
    end

endmodule

// File: rtl/stc_seq_trig.sv
module stc_seq_trig #(
    parameter int DW    = 32,
    parameter int STEPS = 8,
    parameter int OCCW  = 16,
    localparam int SIW  = $clog2(STEPS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       enable,
    input  logic                       smp_v,
    input  logic [DW-1:0]              smp_d,
    input  logic [STEPS-1:0][DW-1:0]   step_val,
    input  logic [STEPS-1:0][DW-1:0]   step_msk,
    input  logic [SIW-1:0]             last_step,
    input  logic [OCCW-1:0]            occ_n,
    input  logic [DW-1:0]              rst_val,
    input  logic [DW-1:0]              rst_msk,
    output logic                       hit
);
    logic [SIW-1:0]   step_q;
    logic [OCCW-1:0]  occ_q;
    logic [OCCW-1:0]  occ_next;
    logic [OCCW-1:0]  occ_eff;
    logic [STEPS-1:0] step_hit;
    logic             cmatch, rmatch, at_last, adv;

    for (genvar s = 0; s < STEPS; s++) begin : g_match
        assign step_hit[s] = ((smp_d ^ step_val[s]) & step_msk[s]) == '0;
    end

    always_comb begin
        cmatch   = step_hit[step_q];
        rmatch   = (rst_msk != '0) && (((smp_d ^ rst_val) & rst_msk) == '0);
        occ_eff  = (occ_n == '0) ? OCCW'(1) : occ_n;
        occ_next = occ_q + 1'b1;
        at_last  = (step_q == last_step);
        adv      = enable && smp_v && !rmatch && cmatch;
        hit      = adv && at_last && (occ_next >= occ_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            occ_q  <= '0;
        end else if (clear || hit) begin
            step_q <= '0;
            occ_q  <= '0;
        end else if (enable && smp_v) begin
            if (rmatch) begin
                step_q <= '0;
                occ_q  <= '0;
            end else if (cmatch) begin
                if (!at_last) step_q <= step_q + 1'b1;
                else          occ_q  <= occ_next;
            end
        end
    end

endmodule

// File: rtl/stc_trace_buf.sv
module stc_trace_buf #(
    parameter int DW    = 32,
    parameter int TAGW  = 24,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = PW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            we,
    input  logic [DW-1:0]   wr_sample,
    input  logic [TAGW-1:0] wr_tag,
    input  logic [PW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_sample,
    output logic [TAGW-1:0] rd_tag,
    output logic [LW-1:0]   len,
    output logic            full
);
    logic [DW+TAGW-1:0] mem [DEPTH];
    logic [PW-1:0]      wptr;
    logic [PW-1:0]      phys;

    assign full = (len == LW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            len  <= '0;
        end else if (clear) begin
            wptr <= '0;
            len  <= '0;
        end else if (we) begin
            wptr <= wptr + 1'b1;
            if (!full) len <= len + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we && !clear) mem[wptr] <= {wr_tag, wr_sample};
    end

    assign phys = wptr - len[PW-1:0] + rd_idx;
    assign {rd_tag, rd_sample} = mem[phys];

endmodule

// File: rtl/seqtrig_capture.sv
module seqtrig_capture
    import stc_pkg::*;
#(
    parameter int DW       = 32,
    parameter int DEPTH    = 64,
    parameter int STEPS    = 8,
    parameter int TAGW     = 24,
    parameter int OCCW     = 16,
    parameter int GROUPS   = 4,
    parameter int SLOW_LIM = 100000,
    parameter int ACT_WIN  = 1000000,
    localparam int PW      = $clog2(DEPTH),
    localparam int LW      = PW + 1,
    localparam int SIW     = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic [DW-1:0]     probe,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [PW-1:0]     rd_idx,
    output logic [DW-1:0]     rd_sample,
    output logic [TAGW-1:0]   rd_tag,
    output logic [LW-1:0]     trace_len,
    output logic [PW-1:0]     trig_idx,
    output logic              done,
    output logic              slow_warn,
    output logic [GROUPS-1:0] act_flags
);
    localparam logic [TAGW-1:0] TAG_MAX = '1;

    // configuration
    logic [STEPS-1:0][DW-1:0] step_val, step_msk;
    logic [SIW-1:0]           last_step;
    pos_e                     pos_mode;
    logic                     store_all, tag_states;
    logic [OCCW-1:0]          occ_n;
    logic [DW-1:0]            rst_val, rst_msk, qual_val, qual_msk;

    // datapath
    logic            smp_v, hit, arm_wr, qualified, wr_en, post_store, buf_full;
    logic [DW-1:0]   smp_d;
    logic [TAGW-1:0] gap_q;
    logic [LW-1:0]   post_tgt, post_cnt;
    cap_state_e      state, nxt;

    assign arm_wr = cfg_we && (cfg_addr == CFG_AW'(A_ARM));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_val   <= '0;
            step_msk   <= '0;
            last_step  <= '0;
            pos_mode   <= POS_START;
            store_all  <= 1'b1;
            tag_states <= 1'b0;
            occ_n      <= '0;
            rst_val    <= '0;
            rst_msk    <= '0;
            qual_val   <= '0;
            qual_msk   <= '0;
        end else if (cfg_we) begin
            for (int k = 0; k < STEPS; k++) begin
                if (cfg_addr == CFG_AW'(A_STEP_VAL + k)) step_val[k] <= cfg_wdata[DW-1:0];
                if (cfg_addr == CFG_AW'(A_STEP_MSK + k)) step_msk[k] <= cfg_wdata[DW-1:0];
            end
            if (cfg_addr == CFG_AW'(A_CTRL)) begin
                last_step  <= cfg_wdata[SIW-1:0];
                pos_mode   <= pos_e'(cfg_wdata[4:3]);
                store_all  <= cfg_wdata[5];
                tag_states <= cfg_wdata[6];
            end
            if (cfg_addr == CFG_AW'(A_OCC))      occ_n    <= cfg_wdata[OCCW-1:0];
            if (cfg_addr == CFG_AW'(A_RST_VAL))  rst_val  <= cfg_wdata[DW-1:0];
            if (cfg_addr == CFG_AW'(A_RST_MSK))  rst_msk  <= cfg_wdata[DW-1:0];
            if (cfg_addr == CFG_AW'(A_QUAL_VAL)) qual_val <= cfg_wdata[DW-1:0];
            if (cfg_addr == CFG_AW'(A_QUAL_MSK)) qual_msk <= cfg_wdata[DW-1:0];
        end
    end

    stc_sampler #(
        .DW(DW), .GROUPS(GROUPS), .SLOW_LIM(SLOW_LIM), .ACT_WIN(ACT_WIN)
    ) u_sampler (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .probe(probe),
        .smp_v(smp_v), .smp_d(smp_d), .slow_warn(slow_warn), .act_flags(act_flags)
    );

    stc_seq_trig #(
        .DW(DW), .STEPS(STEPS), .OCCW(OCCW)
    ) u_trig (
        .clk(clk), .rst_n(rst_n), .clear(arm_wr), .enable(state == ST_PRE),
        .smp_v(smp_v), .smp_d(smp_d), .step_val(step_val), .step_msk(step_msk),
        .last_step(last_step), .occ_n(occ_n), .rst_val(rst_val), .rst_msk(rst_msk),
        .hit(hit)
    );

    stc_trace_buf #(
        .DW(DW), .TAGW(TAGW), .DEPTH(DEPTH)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(arm_wr), .we(wr_en),
        .wr_sample(smp_d), .wr_tag(gap_q), .rd_idx(rd_idx),
        .rd_sample(rd_sample), .rd_tag(rd_tag), .len(trace_len), .full(buf_full)
    );

    assign qualified = store_all || (((smp_d ^ qual_val) & qual_msk) == '0);

    always_comb begin
        case (pos_mode)
            POS_START:  post_tgt = LW'(DEPTH - 1);
            POS_CENTRE: post_tgt = LW'(DEPTH / 2);
            default:    post_tgt = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (arm_wr) begin
            nxt = ST_PRE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_PRE:  if (hit) nxt = (post_tgt == '0) ? ST_DONE : ST_POST;
                ST_POST: if (post_store && (LW'(post_cnt + 1'b1) == post_tgt)) nxt = ST_DONE;
                ST_DONE: nxt = ST_DONE;
            endcase
        end
    end

    // outputs of the controller
    always_comb begin
        wr_en      = 1'b0;
        post_store = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PRE:  wr_en = smp_v && (hit || ((pos_mode != POS_START) && qualified));
            ST_POST: begin
                post_store = smp_v && qualified;
                wr_en      = post_store;
            end
            ST_DONE: done = 1'b1;
        endcase
        if (arm_wr) wr_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_cnt <= '0;
            trig_idx <= '0;
            gap_q    <= '0;
        end else if (arm_wr) begin
            post_cnt <= '0;
            trig_idx <= '0;
            gap_q    <= TAGW'(1);
        end else begin
            if (post_store) post_cnt <= post_cnt + 1'b1;
            if (state == ST_PRE && hit)
                trig_idx <= buf_full ? PW'(DEPTH - 1) : trace_len[PW-1:0];
            else if (post_store && buf_full)
                trig_idx <= trig_idx - 1'b1;
            if (wr_en)
                gap_q <= TAGW'(1);
            else if ((tag_states ? smp_v : 1'b1) && gap_q != TAG_MAX)
                gap_q <= gap_q + 1'b1;
        end
    end

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = PW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [4:0]    cfg_addr,
    input logic          done,
    input logic [LW-1:0] trace_len,
    input logic [PW-1:0] trig_idx
);
    logic arm;
    assign arm = cfg_we && (cfg_addr == 5'd22);

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!done && trace_len == '0)); // R13
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done); // R5
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        trace_len <= LW'(DEPTH)); // R5
    AST_LEN_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> trace_len >= $past(trace_len)); // R5
    AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> $stable(trace_len)); // R5
    AST_TRIG_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({1'b0, trig_idx} < trace_len)); // R6

endmodule

bind seqtrig_capture stc_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .done(done), .trace_len(trace_len), .trig_idx(trig_idx)
);

// File: tb/seqtrig_capture_tb.sv
module seqtrig_capture_tb;
    localparam int TAGW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ext_clk = 1'b0;
    logic [31:0]     probe = '0;
    logic            cfg_we = 1'b0;
    logic [4:0]      cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [5:0]      rd_idx = '0;
    logic [31:0]     rd_sample;
    logic [TAGW-1:0] rd_tag;
    logic [6:0]      trace_len;
    logic [5:0]      trig_idx;
    logic            done, slow_warn;
    logic [3:0]      act_flags;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    seqtrig_capture #(
        .DW(32), .DEPTH(64), .STEPS(8), .TAGW(TAGW), .OCCW(16),
        .GROUPS(4), .SLOW_LIM(200), .ACT_WIN(64)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .probe(probe),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_idx(rd_idx), .rd_sample(rd_sample), .rd_tag(rd_tag),
        .trace_len(trace_len), .trig_idx(trig_idx), .done(done),
        .slow_warn(slow_warn), .act_flags(act_flags)
    );

    // {position, occurrences, expected length, expected trigger index, expected oldest value}
    localparam int TBL [5][5] = '{
        '{0, 1, 64,  0, 7},
        '{1, 1, 40,  7, 0},
        '{1, 3, 64, 31, 8},
        '{2, 3, 40, 39, 0},
        '{2, 5, 64, 63, 8}
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        probe = v; ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input int i, output logic [31:0] s, output logic [TAGW-1:0] t);
        @(negedge clk);
        rd_idx = 6'(i);
        #1;
        s = rd_sample; t = rd_tag;
    endtask

    task automatic setup(input int pos, input int occ, input bit all, input bit states, input int last);
        wr(16, 32'(last) | (32'(pos) << 3) | (32'(all) << 5) | (32'(states) << 6));
        wr(17, 32'(occ));
        wr(22, 32'h0);
    endtask

    task automatic two_steps();
        wr(0, 32'd3); wr(8, 32'hFFFF_FFFF);
        wr(1, 32'd7); wr(9, 32'hFFFF_FFFF);
        wr(19, 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic [TAGW-1:0] t;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 done after reset", done, 0);
        chk("R13 trace_len after reset", trace_len, 0);
        chk("R13 slow_warn after reset", slow_warn, 0);
        chk("R13 act_flags after reset", act_flags, 0);

        // table: trigger position and occurrence count over a mod-16 stream
        two_steps();
        for (int e = 0; e < 5; e++) begin
            setup(TBL[e][0], TBL[e][1], 1'b1, 1'b0, 1);
            for (int k = 0; k < 200 && !done; k++) pulse(32'(k % 16));
            chk("R5 R6 R7 done", done, 1);
            chk("R5 R6 R7 trace_len", trace_len, 64'(TBL[e][2]));
            chk("R3 R6 R7 trig_idx", trig_idx, 64'(TBL[e][3]));
            rd(0, s, t);
            chk("R1 oldest sample", s, 64'(TBL[e][4]));
            rd(TBL[e][2] - 1, s, t);
            chk("R1 newest sample", s, 64'((TBL[e][4] + TBL[e][2] - 1) % 16));
            rd(TBL[e][3], s, t);
            chk("R2 R3 trigger sample", s, 7);
        end

        // R5 frozen after done
        pulse(32'd1); pulse(32'd2); pulse(32'd3);
        chk("R5 len frozen after done", trace_len, 64);
        chk("R5 done held", done, 1);

        // R4 restart pattern
        wr(18, 32'd5); wr(19, 32'hFFFF_FFFF);
        setup(2, 1, 1'b1, 1'b0, 1);
        chk("R13 arm clears len", trace_len, 0);
        pulse(32'd3); pulse(32'd5); pulse(32'd7);
        chk("R4 no trigger after restart", done, 0);
        pulse(32'd3); pulse(32'd7);
        chk("R4 trigger after re-sequence", done, 1);
        chk("R4 length", trace_len, 5);
        wr(19, 32'h0);

        // R2 three steps with a don't-care mask
        wr(0, 32'hA0); wr(8, 32'hF0);
        wr(1, 32'h02); wr(9, 32'hFFFF_FFFF);
        wr(2, 32'h03); wr(10, 32'hFFFF_FFFF);
        setup(2, 1, 1'b1, 1'b0, 2);
        pulse(32'h02); pulse(32'hA5); pulse(32'h03);
        pulse(32'h02); pulse(32'h09);
        chk("R2 not yet triggered", done, 0);
        pulse(32'h03);
        chk("R2 three-step trigger", done, 1);
        chk("R2 length", trace_len, 6);
        chk("R7 trigger is newest", trig_idx, 5);

        // R8 qualifier with R10 state tags
        two_steps();
        wr(20, 32'h0); wr(21, 32'h1);
        setup(0, 1, 1'b0, 1'b1, 1);
        for (int k = 0; k < 200 && !done; k++) pulse(32'(k % 16));
        chk("R8 length", trace_len, 64);
        rd(0, s, t);
        chk("R8 odd trigger stored", s, 7);
        rd(1, s, t);
        chk("R8 first qualified", s, 8);
        chk("R10 state tag adjacent", t, 1);
        rd(2, s, t);
        chk("R8 skips odd", s, 10);
        chk("R10 state tag skip", t, 2);
        rd(63, s, t);
        chk("R8 last qualified", s, 4);

        // R9 cycle tags and saturation, R11 slow clock
        setup(0, 1, 1'b1, 1'b0, 1);
        for (int k = 0; k < 8; k++) pulse(32'(k));
        repeat (1200) @(negedge clk);
        chk("R11 slow_warn after stall", slow_warn, 1);
        pulse(32'd8);
        chk("R11 slow_warn clears", slow_warn, 0);
        pulse(32'd9);
        rd(1, s, t);
        chk("R1 sample after stall", s, 8);
        chk("R9 tag saturates", t, 64'((1 << TAGW) - 1));
        rd(2, s, t);
        chk("R9 tag equals period", t, 8);

        // R12 activity per group
        pulse(32'h0);
        repeat (80) @(negedge clk);
        chk("R12 quiet", act_flags, 0);
        pulse(32'h00FF_0000);
        chk("R12 group two active", act_flags, 4'b0100);
        repeat (80) @(negedge clk);
        chk("R12 window expired", act_flags, 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule